// File: doc/BRIEF.md
# Shared Cartridge Read-Transfer Controller

This block runs command-driven read transfers from a cartridge on behalf of two CPUs, called port A and port B. Each port has its own small register window. An ownership bit in port A's expansion-control register decides which port may control the engine. Software loads an 8-byte command and then writes a control word with the start bit set. The block copies the command into a working latch that the cartridge sees, decodes a block length from a 3-bit size code, and holds a busy flag while the transfer runs.

Each read of the data port by the owner takes one 32-bit word from the cartridge and advances an internal byte position by four. When the position reaches the block length, the engine clears its busy and start bits. If the interrupt enable is set, it then sends a one-cycle completion pulse to the owning port.

The cartridge side is a plain valid/data word source. The block asserts a pop strobe for every word it consumes.

Register select codes, shared by both ports:

| Code | Register |
|------|----------|
| 0 | auxiliary control, 16 bits |
| 1 | control word, 32 bits |
| 2 | command bytes 0 to 3 |
| 3 | command bytes 4 to 7 |
| 4 | the port's own expansion-control copy |
| 5 | data port |

Command byte k sits in lane k mod 4, at bits 8*(k mod 4)+7 to 8*(k mod 4). Each port issues at most one access (read or write) per cycle. Register reads return their data combinationally in the cycle of the access.

Top module: `cart_xfer_ctrl`

## Requirements
- R1: After synchronous reset, the following are all zero: the control word, the auxiliary register, both expansion copies, all command bytes, the working command and both interrupt outputs. Port A is then the owner.
- R2: Bit 11 of port A's expansion copy selects the owner: 0 gives port A, 1 gives port B. The non-owner's writes to the auxiliary register and to the control word change nothing. The non-owner's data-port reads return 0 and consume no word.
- R3: A port A write to select 4 stores data bits 15:0 into A's copy and copies bits 15:7 into B's copy. A port B write to select 4 changes only bits 6:0 of B's copy. Byte enables are not used for this register.
- R4: Auxiliary register writes update the low byte when byte enable 0 is set and the high byte when byte enable 1 is set. Data bits 31:16 are dropped.
- R5: Every control-word write stores the written value with bit 23 forced to 0. A write with bit 31 clear starts nothing.
- R6: Control bits 26:24 give the block length: code 0 gives 0 bytes, code 7 gives 4 bytes, and codes 1 to 6 give 256 shifted left by the code.
- R7: A control write with bit 31 set and a nonzero length copies the 8 command bytes to the working command, clears the position and sets bit 23. Bit 23 is visible from the next cycle.
- R8: A start with length 0 finishes in the same edge. The stored control word has bits 31 and 23 clear.
- R9: Each owner data read during a transfer returns the cartridge word and advances the position by 4. After the read that brings the position to the length, bits 23 and 31 are clear, so exactly length/4 words are read.
- R10: On finish, a single-cycle pulse appears on the owner's interrupt output in the cycle after the finishing edge, only if bit 14 of the auxiliary register is 1. The other output stays low.
- R11: A data read while no transfer is active returns 0. It leaves the position and the control word unchanged.
- R12: An owner data read during a transfer while the cartridge has no valid word returns the last word delivered. It neither advances the position nor pops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_wr | input | 1 | Port A write strobe |
| a_rd | input | 1 | Port A read strobe |
| a_sel | input | 3 | Port A register select |
| a_be | input | 4 | Port A byte enables |
| a_wdata | input | 32 | Port A write data |
| a_rdata | output | 32 | Port A read data |
| b_wr | input | 1 | Port B write strobe |
| b_rd | input | 1 | Port B read strobe |
| b_sel | input | 3 | Port B register select |
| b_be | input | 4 | Port B byte enables |
| b_wdata | input | 32 | Port B write data |
| b_rdata | output | 32 | Port B read data |
| cart_valid | input | 1 | Cartridge word available |
| cart_data | input | 32 | Cartridge word |
| cart_pop | output | 1 | Word consumed this cycle |
| cart_cmd | output | 64 | Working command, byte 0 in bits 7:0 |
| irq_a | output | 1 | Completion pulse to port A |
| irq_b | output | 1 | Completion pulse to port B |

## Verification
The in-RTL properties watch several things on every cycle. They check that the position stays below the length while busy, and that a start loads the busy bit and clears the position. They check that idle and stalled reads never move the position, that completion pulses are gated by the enable and reach at most one port, and that the expansion copies mirror exactly the bits they should. The bench scenarios are needed for the behaviour that spans many cycles or both ports: the data sequence and word count for each size code, the non-owner's writes and reads having no effect, and byte-lane merging in the auxiliary register. They also cover an owner hand-over in the middle of a run of transfers.

// File: rtl/cart_xfer_pkg.sv
package cart_xfer_pkg;

    localparam int WORD_W     = 32;
    localparam int HALF_W     = 16;
    localparam int CMD_BYTES  = 8;
    localparam int CMD_W      = CMD_BYTES * 8;
    localparam int LANES      = WORD_W / 8;
    localparam int SIZE_W     = 15;
    localparam int STEP_BYTES = 4;
    localparam int BLOCK_BASE = 256;

    localparam int CTL_START  = 31;
    localparam int CTL_BUSY   = 23;
    localparam int CTL_SZ_LO  = 24;
    localparam int AUX_IRQ_EN = 14;
    localparam int EXP_OWNER  = 11;
    localparam int EXP_SPLIT  = 7;

    typedef enum logic [2:0] {
        REG_AUX    = 3'd0,
        REG_CTL    = 3'd1,
        REG_CMD_LO = 3'd2,
        REG_CMD_HI = 3'd3,
        REG_EXP    = 3'd4,
        REG_DATA   = 3'd5
    } reg_sel_e;

    typedef struct packed {
        logic              wr;
        logic              rd;
        logic [2:0]        sel;
        logic [LANES-1:0]  be;
        logic [WORD_W-1:0] wdata;
    } bus_req_t;

    function automatic logic [SIZE_W-1:0] block_bytes(input logic [2:0] code);
        case (code)
            3'd0:    return '0;
            3'd7:    return SIZE_W'(STEP_BYTES);
            default: return SIZE_W'(BLOCK_BASE) << code;
        endcase
    endfunction

endpackage

// File: rtl/cart_exp_regs.sv
module cart_exp_regs
    import cart_xfer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_a,
    input  logic              wr_b,
    input  logic [HALF_W-1:0] wdata_a,
    input  logic [HALF_W-1:0] wdata_b,
    output logic [HALF_W-1:0] exp_a,
    output logic [HALF_W-1:0] exp_b,
    output logic              owner_b
);

    localparam logic [HALF_W-1:0] LOW_MASK = HALF_W'((1 << EXP_SPLIT) - 1);
    localparam logic [HALF_W-1:0] HI_MASK  = ~LOW_MASK;

    logic [HALF_W-1:0] hi_src, lo_src;

    always_comb begin
        hi_src = wr_a ? wdata_a : exp_b;
        lo_src = wr_b ? wdata_b : exp_b;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            exp_a <= '0;
            exp_b <= '0;
        end else begin
            if (wr_a) exp_a <= wdata_a;
            exp_b <= (hi_src & HI_MASK) | (lo_src & LOW_MASK);
        end
    end

    assign owner_b = exp_a[EXP_OWNER];

    AST_A_STORES_ALL: assert property (@(posedge clk) disable iff (rst)
        wr_a |=> exp_a == $past(wdata_a)); // R3
    AST_B_HIGH_MIRROR: assert property (@(posedge clk) disable iff (rst)
        wr_a |=> (exp_b & HI_MASK) == ($past(wdata_a) & HI_MASK)); // R3
    AST_B_LOW_KEPT: assert property (@(posedge clk) disable iff (rst)
        !wr_b |=> (exp_b & LOW_MASK) == $past(exp_b & LOW_MASK)); // R3

endmodule

// File: rtl/cart_owner_gate.sv
module cart_owner_gate
    import cart_xfer_pkg::*;
(
    input  logic     owner_b,
    input  bus_req_t req_a,
    input  bus_req_t req_b,
    output bus_req_t own_req,
    output logic     a_owns,
    output logic     b_owns
);

    assign a_owns  = !owner_b;
    assign b_owns  = owner_b;
    assign own_req = owner_b ? req_b : req_a;

endmodule

// File: rtl/cart_xfer_engine.sv
module cart_xfer_engine
    import cart_xfer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_req_t          req,
    input  logic              owner_b,
    input  logic              cart_valid,
    input  logic [WORD_W-1:0] cart_data,
    input  logic [CMD_W-1:0]  cmd_bytes,
    output logic [WORD_W-1:0] ctl_q,
    output logic [HALF_W-1:0] aux_q,
    output logic [CMD_W-1:0]  cart_cmd,
    output logic [WORD_W-1:0] data_word,
    output logic              cart_pop,
    output logic              irq_a,
    output logic              irq_b
);

    logic [SIZE_W-1:0] pos_q, size_q, pos_d, size_d, pos_next, start_size;
    logic [WORD_W-1:0] ctl_d, last_q, last_d;
    logic [HALF_W-1:0] aux_d;
    logic [CMD_W-1:0]  cmd_d;
    logic              busy, hit_ctl, hit_aux, rd_data, finish;

    assign busy       = ctl_q[CTL_BUSY];
    assign hit_ctl    = req.wr && (req.sel == REG_CTL);
    assign hit_aux    = req.wr && (req.sel == REG_AUX);
    assign rd_data    = req.rd && (req.sel == REG_DATA);
    assign cart_pop   = rd_data && busy && cart_valid;
    assign pos_next   = pos_q + SIZE_W'(STEP_BYTES);
    assign start_size = block_bytes(req.wdata[CTL_SZ_LO +: 3]);
    assign data_word  = !busy ? '0 : (cart_valid ? cart_data : last_q);

    always_comb begin
        ctl_d  = ctl_q;
        pos_d  = pos_q;
        size_d = size_q;
        cmd_d  = cart_cmd;
        last_d = last_q;
        aux_d  = aux_q;
        finish = 1'b0;
        if (hit_ctl) begin
            ctl_d           = req.wdata;
            ctl_d[CTL_BUSY] = 1'b0;
            if (req.wdata[CTL_START]) begin
                cmd_d  = cmd_bytes;
                pos_d  = '0;
                size_d = start_size;
                if (start_size == '0) begin
                    ctl_d[CTL_START] = 1'b0;
                    finish           = 1'b1;
                end else begin
                    ctl_d[CTL_BUSY] = 1'b1;
                end
            end
        end else if (cart_pop) begin
            pos_d  = pos_next;
            last_d = cart_data;
            if (pos_next >= size_q) begin
                ctl_d[CTL_BUSY]  = 1'b0;
                ctl_d[CTL_START] = 1'b0;
                finish           = 1'b1;
            end
        end
        if (hit_aux) begin
            if (req.be[0]) aux_d[7:0]  = req.wdata[7:0];
            if (req.be[1]) aux_d[15:8] = req.wdata[15:8];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q    <= '0;
            aux_q    <= '0;
            pos_q    <= '0;
            size_q   <= '0;
            cart_cmd <= '0;
            last_q   <= '0;
            irq_a    <= 1'b0;
            irq_b    <= 1'b0;
        end else begin
            ctl_q    <= ctl_d;
            aux_q    <= aux_d;
            pos_q    <= pos_d;
            size_q   <= size_d;
            cart_cmd <= cmd_d;
            last_q   <= last_d;
            irq_a    <= finish && aux_q[AUX_IRQ_EN] && !owner_b;
            irq_b    <= finish && aux_q[AUX_IRQ_EN] && owner_b;
        end
    end

    AST_POS_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        busy |-> pos_q < size_q); // R9
    AST_START_LOADS: assert property (@(posedge clk) disable iff (rst)
        hit_ctl && req.wdata[CTL_START] && (block_bytes(req.wdata[CTL_SZ_LO +: 3]) != '0)
        |=> ctl_q[CTL_BUSY] && (pos_q == '0)); // R7
    AST_IRQ_ONE_TARGET: assert property (@(posedge clk) disable iff (rst)
        $onehot0({irq_a, irq_b})); // R10
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        (irq_a || irq_b) |-> aux_q[AUX_IRQ_EN]); // R10
    AST_IDLE_READ_STILL: assert property (@(posedge clk) disable iff (rst)
        rd_data && !busy |=> $stable(pos_q)); // R11
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        rd_data && busy && !cart_valid && !hit_ctl |=> $stable(pos_q) && ctl_q[CTL_BUSY]); // R12

endmodule

// File: rtl/cart_xfer_ctrl.sv
module cart_xfer_ctrl
    import cart_xfer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              a_wr,
    input  logic              a_rd,
    input  logic [2:0]        a_sel,
    input  logic [LANES-1:0]  a_be,
    input  logic [WORD_W-1:0] a_wdata,
    output logic [WORD_W-1:0] a_rdata,
    input  logic              b_wr,
    input  logic              b_rd,
    input  logic [2:0]        b_sel,
    input  logic [LANES-1:0]  b_be,
    input  logic [WORD_W-1:0] b_wdata,
    output logic [WORD_W-1:0] b_rdata,
    input  logic              cart_valid,
    input  logic [WORD_W-1:0] cart_data,
    output logic              cart_pop,
    output logic [CMD_W-1:0]  cart_cmd,
    output logic              irq_a,
    output logic              irq_b
);

    bus_req_t          req [2];
    bus_req_t          own_req;
    logic              owns [2];
    logic [HALF_W-1:0] exp_copy [2];
    logic [WORD_W-1:0] rdata [2];
    logic [CMD_W-1:0]  cmd_q;
    logic [WORD_W-1:0] ctl_q, data_word;
    logic [HALF_W-1:0] aux_q;
    logic              owner_b;

    assign req[0] = '{wr: a_wr, rd: a_rd, sel: a_sel, be: a_be, wdata: a_wdata};
    assign req[1] = '{wr: b_wr, rd: b_rd, sel: b_sel, be: b_be, wdata: b_wdata};

    cart_exp_regs u_exp (
        .clk     (clk),
        .rst     (rst),
        .wr_a    (a_wr && (a_sel == REG_EXP)),
        .wr_b    (b_wr && (b_sel == REG_EXP)),
        .wdata_a (a_wdata[HALF_W-1:0]),
        .wdata_b (b_wdata[HALF_W-1:0]),
        .exp_a   (exp_copy[0]),
        .exp_b   (exp_copy[1]),
        .owner_b (owner_b)
    );

    cart_owner_gate u_gate (
        .owner_b (owner_b),
        .req_a   (req[0]),
        .req_b   (req[1]),
        .own_req (own_req),
        .a_owns  (owns[0]),
        .b_owns  (owns[1])
    );

    cart_xfer_engine u_eng (
        .clk        (clk),
        .rst        (rst),
        .req        (own_req),
        .owner_b    (owner_b),
        .cart_valid (cart_valid),
        .cart_data  (cart_data),
        .cmd_bytes  (cmd_q),
        .ctl_q      (ctl_q),
        .aux_q      (aux_q),
        .cart_cmd   (cart_cmd),
        .data_word  (data_word),
        .cart_pop   (cart_pop),
        .irq_a      (irq_a),
        .irq_b      (irq_b)
    );

    // Command bytes are writable from either port; port A wins a same-cycle clash.
    for (genvar k = 0; k < CMD_BYTES; k++) begin : g_cmd
        localparam logic [2:0] WIN  = (k < LANES) ? REG_CMD_LO : REG_CMD_HI;
        localparam int         LANE = k % LANES;
        logic hit_a, hit_b;
        assign hit_a = a_wr && (a_sel == WIN) && a_be[LANE];
        assign hit_b = b_wr && (b_sel == WIN) && b_be[LANE];
        always_ff @(posedge clk) begin
            if (rst)        cmd_q[k*8 +: 8] <= '0;
            else if (hit_a) cmd_q[k*8 +: 8] <= a_wdata[LANE*8 +: 8];
            else if (hit_b) cmd_q[k*8 +: 8] <= b_wdata[LANE*8 +: 8];
        end
    end

    for (genvar p = 0; p < 2; p++) begin : g_view
        always_comb begin
            case (req[p].sel)
                REG_AUX:    rdata[p] = {{(WORD_W-HALF_W){1'b0}}, aux_q};
                REG_CTL:    rdata[p] = ctl_q;
                REG_CMD_LO: rdata[p] = cmd_q[WORD_W-1:0];
                REG_CMD_HI: rdata[p] = cmd_q[CMD_W-1:WORD_W];
                REG_EXP:    rdata[p] = {{(WORD_W-HALF_W){1'b0}}, exp_copy[p]};
                REG_DATA:   rdata[p] = owns[p] ? data_word : '0;
                default:    rdata[p] = '0;
            endcase
        end
    end

    assign a_rdata = rdata[0];
    assign b_rdata = rdata[1];

endmodule

// File: tb/tb_cart_xfer_ctrl.sv
`timescale 1ns/1ps
module tb_cart_xfer_ctrl;
    import cart_xfer_pkg::*;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst;
    logic        a_wr = 0, a_rd = 0, b_wr = 0, b_rd = 0;
    logic [2:0]  a_sel = 0, b_sel = 0;
    logic [3:0]  a_be = 0, b_be = 0;
    logic [31:0] a_wdata = 0, b_wdata = 0, a_rdata, b_rdata;
    logic        cart_valid = 1'b1;
    logic [31:0] cart_data, cart_idx;
    logic        cart_pop, irq_a, irq_b;
    logic [63:0] cart_cmd;

    int checks = 0, errors = 0, next_word = 0;
    bit done = 0;

    cart_xfer_ctrl dut (
        .clk(clk), .rst(rst),
        .a_wr(a_wr), .a_rd(a_rd), .a_sel(a_sel), .a_be(a_be), .a_wdata(a_wdata), .a_rdata(a_rdata),
        .b_wr(b_wr), .b_rd(b_rd), .b_sel(b_sel), .b_be(b_be), .b_wdata(b_wdata), .b_rdata(b_rdata),
        .cart_valid(cart_valid), .cart_data(cart_data), .cart_pop(cart_pop),
        .cart_cmd(cart_cmd), .irq_a(irq_a), .irq_b(irq_b)
    );

    // cartridge model: numbered words
    always_ff @(posedge clk) begin
        if (rst)           cart_idx <= 0;
        else if (cart_pop) cart_idx <= cart_idx + 1;
    end
    assign cart_data = 32'hCA00_0000 | cart_idx;

    function automatic logic [31:0] word_of(input int n);
        return 32'hCA00_0000 | n;
    endfunction

    function automatic int exp_bytes(input int code);
        if (code == 0) return 0;
        if (code == 7) return 4;
        return 256 << code;
    endfunction

    task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic op(input int cpu, input bit w, input logic [2:0] sel, input logic [3:0] be,
                      input logic [31:0] d, output logic [31:0] q);
        @(negedge clk);
        if (cpu == 0) begin a_wr = w; a_rd = !w; a_sel = sel; a_be = be; a_wdata = d; end
        else          begin b_wr = w; b_rd = !w; b_sel = sel; b_be = be; b_wdata = d; end
        #1 q = (cpu == 0) ? a_rdata : b_rdata;
        @(posedge clk);
        #1;
        a_wr = 0; a_rd = 0; b_wr = 0; b_rd = 0;
    endtask

    task automatic wr(input int cpu, input logic [2:0] sel, input logic [3:0] be, input logic [31:0] d);
        logic [31:0] q;
        op(cpu, 1'b1, sel, be, d, q);
    endtask

    task automatic rd(input int cpu, input logic [2:0] sel, output logic [31:0] q);
        op(cpu, 1'b0, sel, 4'h0, 32'h0, q);
    endtask

    task automatic set_owner(input int who);
        wr(0, REG_EXP, 4'h3, (who == 1) ? 32'h0000_0800 : 32'h0);
    endtask

    task automatic xfer(input int cpu, input int code, input bit en);
        logic [31:0] q;
        int n, bad;
        logic [1:0] irq_exp;
        bad = 0;
        irq_exp = !en ? 2'b00 : ((cpu == 0) ? 2'b01 : 2'b10);
        n = exp_bytes(code) / 4;
        wr(cpu, REG_AUX, 4'h3, en ? 32'h4000 : 32'h0);
        wr(cpu, REG_CTL, 4'hF, 32'h8000_0000 | (code << 24));
        if (n == 0) begin
            chk("R8/R10 irq on zero-length start", {irq_b, irq_a}, irq_exp);
            rd(cpu, REG_CTL, q);
            chk("R8 zero length clears start", q, 32'(code << 24));
        end else begin
            rd(cpu, REG_CTL, q);
            chk("R7 busy after start", q, 32'h8080_0000 | (code << 24));
            for (int i = 0; i < n; i++) begin
                if (i == n - 1) begin
                    rd(cpu, REG_CTL, q);
                    chk("R6 still busy before last word", q[23], 1'b1);
                end
                rd(cpu, REG_DATA, q);
                if (q !== word_of(next_word)) bad++;
                next_word++;
            end
            chk("R10 completion pulse", {irq_b, irq_a}, irq_exp);
            chk("R9 word sequence mismatches", bad, 0);
            rd(cpu, REG_CTL, q);
            chk("R9 finish clears bits 31 and 23", q, 32'(code << 24));
            chk("R10 pulse lasts one cycle", {irq_b, irq_a}, 2'b00);
        end
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R9 watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] q;
        void'($urandom(32'd20240611));
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        chk("R1 irq outputs", {irq_b, irq_a}, 2'b00);
        chk("R1 working command", cart_cmd, 64'h0);
        rd(0, REG_CTL, q); chk("R1 control word", q, 32'h0);
        rd(1, REG_AUX, q); chk("R1 aux register", q, 32'h0);
        rd(0, REG_EXP, q); chk("R1 expansion A", q, 32'h0);
        rd(1, REG_EXP, q); chk("R1 expansion B", q, 32'h0);

        // R3 expansion mirror
        wr(0, REG_EXP, 4'h0, 32'hDEAD_F0A5);
        rd(0, REG_EXP, q); chk("R3 A stores 16 bits", q, 32'h0000_F0A5);
        rd(1, REG_EXP, q); chk("R3 B gets bits 15:7", q, 32'h0000_F080);
        wr(1, REG_EXP, 4'hF, 32'h0000_1234);
        rd(1, REG_EXP, q); chk("R3 B write only bits 6:0", q, 32'h0000_F0B4);
        rd(0, REG_EXP, q); chk("R3 B write leaves A", q, 32'h0000_F0A5);
        set_owner(0);

        // R4 aux byte lanes
        wr(0, REG_AUX, 4'h1, 32'h0000_AB11);
        rd(0, REG_AUX, q); chk("R4 low byte lane", q, 32'h0000_0011);
        wr(0, REG_AUX, 4'h2, 32'h0000_4299);
        rd(0, REG_AUX, q); chk("R4 high byte lane", q, 32'h0000_4211);
        wr(0, REG_AUX, 4'hF, 32'hFFFF_C003);
        rd(0, REG_AUX, q); chk("R4 upper half dropped", q, 32'h0000_C003);
        wr(0, REG_AUX, 4'h3, 32'h4000);

        // R2 non-owner writes ignored
        wr(1, REG_AUX, 4'h3, 32'hFFFF);
        rd(0, REG_AUX, q); chk("R2 non-owner aux write ignored", q, 32'h4000);
        wr(1, REG_CTL, 4'hF, 32'h8700_0000);
        rd(1, REG_CTL, q); chk("R2 non-owner control write ignored", q, 32'h0);

        // R5 bit 23 forced low, no start
        wr(0, REG_CTL, 4'hF, 32'h00FF_FFFF);
        rd(0, REG_CTL, q); chk("R5 bit 23 forced 0", q, 32'h007F_FFFF);
        chk("R5 no start, no pulse", {irq_b, irq_a}, 2'b00);
        wr(0, REG_CTL, 4'hF, 32'h0);

        // R7 command latch, R2 non-owner data read
        wr(0, REG_CMD_LO, 4'hF, 32'h3322_1100);
        wr(1, REG_CMD_HI, 4'hF, 32'h7766_5544);
        wr(0, REG_CTL, 4'hF, 32'h8700_0000);
        chk("R7 working command copied", cart_cmd, 64'h7766_5544_3322_1100);
        rd(1, REG_DATA, q); chk("R2 non-owner data read is 0", q, 32'h0);
        rd(0, REG_DATA, q); chk("R9 first word", q, word_of(next_word)); next_word++;
        chk("R10 pulse to A", {irq_b, irq_a}, 2'b01);
        rd(0, REG_CTL, q); chk("R9 size-7 done after one word", q, 32'h0700_0000);

        // R11 idle read
        rd(0, REG_DATA, q); chk("R11 idle read returns 0", q, 32'h0);
        rd(0, REG_CTL, q); chk("R11 control unchanged", q, 32'h0700_0000);

        // R8 zero length
        xfer(0, 0, 1'b1);

        // R12 stall
        wr(0, REG_CTL, 4'hF, 32'h8700_0000);
        cart_valid = 1'b0;
        rd(0, REG_DATA, q); chk("R12 stall returns last word", q, word_of(next_word - 1));
        rd(0, REG_CTL, q); chk("R12 still busy while stalled", q, 32'h8780_0000);
        cart_valid = 1'b1;
        rd(0, REG_DATA, q); chk("R12 word after stall", q, word_of(next_word)); next_word++;
        chk("R12 finish after stall", {irq_b, irq_a}, 2'b01);

        // R10 disabled pulse, R6 large block
        xfer(0, 7, 1'b0);
        xfer(0, 6, 1'b1);

        // owner hand-over to B
        set_owner(1);
        rd(0, REG_DATA, q); chk("R2 A not owner reads 0", q, 32'h0);
        xfer(1, 1, 1'b1);
        wr(0, REG_AUX, 4'h3, 32'h0);
        rd(1, REG_AUX, q); chk("R2 A aux write ignored under B", q, 32'h4000);

        // random mix
        for (int it = 0; it < 30; it++) begin
            int who, code;
            bit en;
            who  = $urandom % 2;
            code = $urandom % 8;
            if (code == 5 || code == 6) code = 7;
            en = $urandom % 2;
            set_owner(who);
            xfer(who, code, en);
            wr(1 - who, REG_AUX, 4'h3, 32'hFFFF);
            rd(who, REG_AUX, q); chk("R2 random non-owner aux", q, en ? 32'h4000 : 32'h0);
            wr(1 - who, REG_CTL, 4'hF, 32'h8100_0000);
            rd(who, REG_CTL, q); chk("R2 random non-owner control", q, 32'(code << 24));
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule